// File: doc/BRIEF.md
# Vectored Nested-Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents one request line to a processor. Each source carries a small mode word that holds a 3-bit priority and a trigger style: level or edge, either polarity. Each source also has a vector word that software loads with a handler address or tag. Per-source mask bits and pending bits are changed through write-ones command words, so one store never disturbs the bits it does not name. A software set command can force any pending bit, which allows an interrupt to be retriggered.

Reading the acknowledge word has a side effect. It returns the vector of the winning source and pushes that source's number and priority onto a hardware nesting stack. The request line is then held back until something of strictly higher priority is pending. Each write to the end-of-service word pops one level. When no source is eligible, the acknowledge read returns a software-loaded spurious vector and changes no state. The stack has eight entries, so eight end-of-service writes always return the controller to idle.

Top module: `vic_ctrl`

Register words, as byte offsets: mode of source n at 0x000+4n; vector of source n at 0x080+4n; acknowledge (read) 0x100; current source number (read) 0x104; pending (read) 0x108; mask (read) 0x10C; mask-enable command 0x110; mask-disable command 0x114; pending-set command 0x118; pending-clear command 0x11C; end-of-service 0x120; spurious vector (read/write) 0x124. Mode word fields: bits [2:0] priority (7 highest); bit 4 set selects edge trigger; bit 5 set selects active-low level or falling edge. Other bits read as 0.

## Requirements
- R1: After reset the mask and every mode word are 0, the pending word is 0 while all inputs are low, irq_o is low, the current-source word reads 0, and an acknowledge read returns the spurious vector, which resets to 0.
- R2: A write to 0x110 sets the mask bits where the data has ones, and a write to 0x114 clears them; zero data bits leave mask bits unchanged.
- R3: A write to 0x118 sets the pending bits where the data has ones, and a write to 0x11C clears the software-latched part of those pending bits; a forced bit on an enabled source raises irq_o.
- R4: An edge-mode source (mode bit 4 = 1) latches pending on the rising edge of its two-flop synchronised input when bit 5 = 0, or on the falling edge when bit 5 = 1; the opposite edge and a held level latch nothing.
- R5: A level-mode source (mode bit 4 = 0) shows pending while its synchronised input is high (bit 5 = 0) or low (bit 5 = 1) and drops pending when the input leaves that level.
- R6: Among enabled pending sources the highest priority wins, and among equal priorities the lowest source number wins.
- R7: irq_o is high only when the winner's priority is strictly above the priority on top of the nesting stack; with an empty stack any enabled pending source raises it.
- R8: An acknowledge read while irq_o is high returns the winner's vector, pushes the winner onto the stack so that 0x104 reads its number, and clears that source's latched pending bit.
- R9: An acknowledge read while irq_o is low returns the spurious vector and changes neither the stack nor any pending bit.
- R10: Each write to 0x120 pops one nesting level; after eight pushes, eight such writes empty the stack, and a write on an empty stack has no effect.
- R11: A mode word reads back its priority in bits [2:0] and its trigger bits in 4 and 5, with all other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt inputs, one per source |
| bus_addr | input | 9 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; carries the acknowledge side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench aims at equal-priority ties, where a picker that scanned the wrong way would return the vector of the higher-numbered source. It fills all eight nesting levels and then counts end-of-service writes one by one. An off-by-one stack pointer would show the wrong current source, or keep the request line blocked after the eighth pop. Edge sources get the opposite edge and a held level, which a detector keyed to level or to the wrong polarity would latch. The bench also makes acknowledge reads with no eligible source and checks that nothing is pushed and no pending bit is lost, since a design that acknowledged regardless would corrupt the nesting.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // word indices (byte offset >> 2) of the control words
   localparam int unsigned W_ACK   = 64;
   localparam int unsigned W_CUR   = 65;
   localparam int unsigned W_PEND  = 66;
   localparam int unsigned W_MASK  = 67;
   localparam int unsigned W_MEN   = 68;
   localparam int unsigned W_MDIS  = 69;
   localparam int unsigned W_PSET  = 70;
   localparam int unsigned W_PCLR  = 71;
   localparam int unsigned W_EOS   = 72;
   localparam int unsigned W_SPUR  = 73;
   // word regions for the per-source tables
   localparam int unsigned W_MODE0 = 0;
   localparam int unsigned W_VEC0  = 32;
   localparam int unsigned REGION  = 32;
   // mode word bit positions
   localparam int unsigned MB_EDGE = 4;
   localparam int unsigned MB_INV  = 5;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic edge_mode_i,
   input  logic invert_i,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   logic [1:0] sync_q;
   logic       prev_q;
   logic       lat_q;
   logic       rise, fall, edge_hit, level_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], src_i};
         prev_q <= sync_q[1];
      end
   end

   assign rise     = sync_q[1] & ~prev_q;
   assign fall     = ~sync_q[1] & prev_q;
   assign edge_hit = edge_mode_i & (invert_i ? fall : rise);
   assign level_on = ~edge_mode_i & (sync_q[1] ^ invert_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lat_q <= 1'b0;
      else if (edge_hit || set_i) lat_q <= 1'b1;
      else if (clr_i)             lat_q <= 1'b0;
   end

   assign pend_o = lat_q | level_on;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned SRC_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]             req_i,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                         valid_o,
   output logic [SRC_W-1:0]             idx_o,
   output logic [PRIO_W-1:0]            prio_o
);
   // descending scan with >= keeps the lowest index on a tie
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
            valid_o = 1'b1;
            idx_o   = SRC_W'(i);
            prio_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned SRC_W  = 5,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned DW    = $clog2(DEPTH + 1),
   localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [SRC_W-1:0]  push_src_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic [DW-1:0]     depth_o,
   output logic [SRC_W-1:0]  top_src_o,
   output logic [PRIO_W-1:0] top_prio_o
);
   logic [SRC_W-1:0]  src_q  [DEPTH];
   logic [PRIO_W-1:0] prio_q [DEPTH];
   logic [DW-1:0]     depth_q;
   logic [PW-1:0]     top_ptr;

   assign top_ptr = (depth_q == '0) ? '0 : PW'(depth_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            src_q[i]  <= '0;
            prio_q[i] <= '0;
         end
      end else if (push_i && depth_q < DW'(DEPTH)) begin
         src_q[PW'(depth_q)]  <= push_src_i;
         prio_q[PW'(depth_q)] <= push_prio_i;
         depth_q              <= depth_q + 1'b1;
      end else if (pop_i && depth_q != '0) begin
         depth_q <= depth_q - 1'b1;
      end
   end

   assign depth_o    = depth_q;
   assign top_src_o  = src_q[top_ptr];
   assign top_prio_o = prio_q[top_ptr];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
   parameter int unsigned N_SRC      = 32,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned NEST_DEPTH = 8,
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import vic_pkg::*;

   localparam int unsigned SRC_W   = $clog2(N_SRC);
   localparam int unsigned DEPTH_W = $clog2(NEST_DEPTH + 1);
   localparam int unsigned WORD_W  = ADDR_W - 2;

   generate
      if (N_SRC < 2 || N_SRC > REGION) begin : g_bad_nsrc
         $error("vic_ctrl: N_SRC must lie in 2..32");
      end
      if (PRIO_W < 1 || PRIO_W > MB_EDGE) begin : g_bad_prio
         $error("vic_ctrl: PRIO_W must lie in 1..4");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("vic_ctrl: ADDR_W must be at least 9");
      end
      if (DATA_W < N_SRC || DATA_W < 8) begin : g_bad_data
         $error("vic_ctrl: DATA_W too narrow");
      end
      if (NEST_DEPTH < (1 << PRIO_W)) begin : g_bad_depth
         $error("vic_ctrl: NEST_DEPTH must cover every priority level");
      end
   endgenerate

   logic [WORD_W-1:0]             word;
   logic [N_SRC-1:0][PRIO_W-1:0]  prio_q;
   logic [N_SRC-1:0]              edge_q, inv_q;
   logic [DATA_W-1:0]             vec_q [N_SRC];
   logic [N_SRC-1:0]              mask_q;
   logic [DATA_W-1:0]             spur_q;
   logic [N_SRC-1:0]              pend;
   logic                          win_valid;
   logic [SRC_W-1:0]              win_idx;
   logic [PRIO_W-1:0]             win_prio;
   logic [DEPTH_W-1:0]            depth;
   logic [SRC_W-1:0]              top_src;
   logic [PRIO_W-1:0]             top_prio;
   logic [PRIO_W:0]               win_lvl, top_lvl;
   logic                          ack_fire, eos_fire;
   logic                          wr_set, wr_clr, wr_men, wr_mdis, wr_spur;

   assign word    = bus_addr[ADDR_W-1:2];
   assign wr_set  = bus_wr && word == WORD_W'(W_PSET);
   assign wr_clr  = bus_wr && word == WORD_W'(W_PCLR);
   assign wr_men  = bus_wr && word == WORD_W'(W_MEN);
   assign wr_mdis = bus_wr && word == WORD_W'(W_MDIS);
   assign wr_spur = bus_wr && word == WORD_W'(W_SPUR);
   assign eos_fire = bus_wr && word == WORD_W'(W_EOS);
   assign ack_fire = bus_rd && word == WORD_W'(W_ACK) && irq_o;

   // per-source configuration words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         edge_q <= '0;
         inv_q  <= '0;
         for (int i = 0; i < N_SRC; i++) vec_q[i] <= '0;
      end else if (bus_wr) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (word == WORD_W'(W_MODE0 + i)) begin
               prio_q[i] <= bus_wdata[PRIO_W-1:0];
               edge_q[i] <= bus_wdata[MB_EDGE];
               inv_q[i]  <= bus_wdata[MB_INV];
            end
            if (word == WORD_W'(W_VEC0 + i)) vec_q[i] <= bus_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         spur_q <= '0;
      end else begin
         if (wr_men)  mask_q <= mask_q | bus_wdata[N_SRC-1:0];
         if (wr_mdis) mask_q <= mask_q & ~bus_wdata[N_SRC-1:0];
         if (wr_spur) spur_q <= bus_wdata;
      end
   end

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         vic_src_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (src_i[g]),
            .edge_mode_i (edge_q[g]),
            .invert_i    (inv_q[g]),
            .set_i       (wr_set && bus_wdata[g]),
            .clr_i       ((wr_clr && bus_wdata[g]) ||
                          (ack_fire && win_idx == SRC_W'(g))),
            .pend_o      (pend[g])
         );
      end
   endgenerate

   vic_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
      .req_i   (pend & mask_q),
      .prio_i  (prio_q),
      .valid_o (win_valid),
      .idx_o   (win_idx),
      .prio_o  (win_prio)
   );

   vic_nest_stack #(.DEPTH(NEST_DEPTH), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (ack_fire),
      .push_src_i  (win_idx),
      .push_prio_i (win_prio),
      .pop_i       (eos_fire),
      .depth_o     (depth),
      .top_src_o   (top_src),
      .top_prio_o  (top_prio)
   );

   // levels are offset by one so that an empty stack sits below priority 0
   assign win_lvl = {1'b0, win_prio} + 1'b1;
   assign top_lvl = (depth == '0) ? '0 : {1'b0, top_prio} + 1'b1;
   assign irq_o   = win_valid && (win_lvl > top_lvl) &&
                    (depth < DEPTH_W'(NEST_DEPTH));

   always_comb begin
      bus_rdata = '0;
      if (word < WORD_W'(W_VEC0)) begin
         for (int i = 0; i < N_SRC; i++)
            if (word == WORD_W'(W_MODE0 + i))
               bus_rdata = DATA_W'({inv_q[i], edge_q[i], {(MB_EDGE - PRIO_W){1'b0}}, prio_q[i]});
      end else if (word < WORD_W'(W_VEC0 + REGION)) begin
         for (int i = 0; i < N_SRC; i++)
            if (word == WORD_W'(W_VEC0 + i)) bus_rdata = vec_q[i];
      end else begin
         case (word)
            WORD_W'(W_ACK):  bus_rdata = irq_o ? vec_q[win_idx] : spur_q;
            WORD_W'(W_CUR):  bus_rdata = (depth == '0) ? '0 : DATA_W'(top_src);
            WORD_W'(W_PEND): bus_rdata = DATA_W'(pend);
            WORD_W'(W_MASK): bus_rdata = DATA_W'(mask_q);
            WORD_W'(W_SPUR): bus_rdata = spur_q;
            default:         bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
   parameter int unsigned N_SRC      = 32,
   parameter int unsigned NEST_DEPTH = 8,
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DEPTH_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq,
   input logic [N_SRC-1:0]   pend,
   input logic [N_SRC-1:0]   mask,
   input logic [DEPTH_W-1:0] depth,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata
);
   logic is_ack, is_eos, is_men;
   assign is_ack = bus_addr == ADDR_W'(9'h100);
   assign is_eos = bus_addr == ADDR_W'(9'h120);
   assign is_men = bus_addr == ADDR_W'(9'h110);

   // R7
   irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(pend & mask)));

   // R8
   ack_pushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && is_ack && irq) |=> depth == $past(depth) + 1'b1);

   // R9
   spurious_keeps_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && is_ack && !irq && !bus_wr) |=> $stable(depth));

   // R10
   eos_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_eos && depth != '0) |=> depth == $past(depth) - 1'b1);

   // R10
   stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DEPTH_W'(NEST_DEPTH));

   // R2
   enable_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_men) |=> (mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]));
endmodule

bind vic_ctrl vic_ctrl_chk #(
   .N_SRC(N_SRC), .NEST_DEPTH(NEST_DEPTH), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .DEPTH_W($clog2(NEST_DEPTH + 1))
) u_vic_ctrl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq_o),
   .pend      (pend),
   .mask      (mask_q),
   .depth     (depth),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata)
);

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [8:0] A_ACK = 9'h100, A_CUR = 9'h104, A_PEND = 9'h108,
                          A_MASK = 9'h10C, A_MEN = 9'h110, A_MDIS = 9'h114,
                          A_PSET = 9'h118, A_PCLR = 9'h11C, A_EOS = 9'h120,
                          A_SPUR = 9'h124;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [8:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_tests = 0, n_fail = 0;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vic_ctrl u_vic_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [8:0] a_mode(input int n); return 9'(4 * n); endfunction
   function automatic logic [8:0] a_vec(input int n);  return 9'(9'h080 + 4 * n); endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #(CLK_PERIOD/4) d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic chk_rd(input string req, input string what,
                         input logic [8:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, what, d, exp);
   endtask

   task automatic chk_irq(input string req, input string what, input logic exp);
      @(negedge clk); #1;
      check(req, what, 32'(irq_o), 32'(exp));
   endtask

   task automatic t_reset;
      chk_irq("R1", "irq after reset", 1'b0);
      chk_rd("R1", "mask after reset", A_MASK, 32'h0);
      chk_rd("R1", "pending after reset", A_PEND, 32'h0);
      chk_rd("R1", "current after reset", A_CUR, 32'h0);
      chk_rd("R1", "mode 9 after reset", a_mode(9), 32'h0);
      chk_rd("R1", "ack after reset gives spurious 0", A_ACK, 32'h0);
      for (int i = 0; i < 32; i++) wr(a_vec(i), 32'hA00 + 32'(i));
      chk_rd("R1", "vector 17 readback", a_vec(17), 32'hA11);
   endtask

   task automatic t_mode_fields;
      wr(a_mode(5), 32'hFFFF_FFFF);
      chk_rd("R11", "mode field readback", a_mode(5), 32'h37);
      wr(a_mode(5), 32'h0);
   endtask

   task automatic t_mask;
      wr(A_MEN, 32'h0000_00F0);
      chk_rd("R2", "enable sets ones", A_MASK, 32'h0000_00F0);
      wr(A_MEN, 32'h0000_0003);
      chk_rd("R2", "enable zeros keep bits", A_MASK, 32'h0000_00F3);
      wr(A_MDIS, 32'h0000_0010);
      chk_rd("R2", "disable clears ones only", A_MASK, 32'h0000_00E3);
      wr(A_MDIS, 32'hFFFF_FFFF);
      chk_rd("R2", "disable all", A_MASK, 32'h0);
   endtask

   task automatic t_soft;
      wr(A_PSET, 32'h0000_0020);
      chk_rd("R3", "set forces pending", A_PEND, 32'h0000_0020);
      chk_irq("R3", "masked forced source no irq", 1'b0);
      wr(A_MEN, 32'h0000_0020);
      chk_irq("R3", "enabled forced source raises irq", 1'b1);
      wr(A_PCLR, 32'h0000_0020);
      chk_rd("R3", "clear drops pending", A_PEND, 32'h0);
      chk_irq("R3", "irq drops after clear", 1'b0);
      wr(A_MDIS, 32'hFFFF_FFFF);
   endtask

   task automatic t_level;
      wr(a_mode(3), 32'h02);
      src_i[3] = 1'b1; idle(4);
      chk_rd("R5", "active-high level pending", A_PEND, 32'h0000_0008);
      src_i[3] = 1'b0; idle(4);
      chk_rd("R5", "active-high level released", A_PEND, 32'h0);
      wr(a_mode(4), 32'h20); idle(1);
      chk_rd("R5", "active-low level pending at 0", A_PEND, 32'h0000_0010);
      src_i[4] = 1'b1; idle(4);
      chk_rd("R5", "active-low level released at 1", A_PEND, 32'h0);
      src_i[4] = 1'b0; idle(4);
      wr(a_mode(4), 32'h00);
      chk_rd("R5", "level back to idle", A_PEND, 32'h0);
   endtask

   task automatic t_edge;
      wr(a_mode(6), 32'h11);
      src_i[6] = 1'b1; idle(4);
      chk_rd("R4", "rising edge latched", A_PEND, 32'h0000_0040);
      wr(A_PCLR, 32'h0000_0040); idle(4);
      chk_rd("R4", "held high does not relatch", A_PEND, 32'h0);
      src_i[6] = 1'b0; idle(4);
      chk_rd("R4", "falling edge ignored in rising mode", A_PEND, 32'h0);
      wr(a_mode(7), 32'h34);
      src_i[7] = 1'b1; idle(4);
      chk_rd("R4", "rising ignored in falling mode", A_PEND, 32'h0);
      src_i[7] = 1'b0; idle(4);
      chk_rd("R4", "falling edge latched", A_PEND, 32'h0000_0080);
      wr(A_MEN, 32'h0000_0080);
      chk_rd("R8", "ack of edge source vector", A_ACK, 32'hA07);
      chk_rd("R8", "ack clears edge pending", A_PEND, 32'h0);
      chk_rd("R8", "current is 7", A_CUR, 32'd7);
      wr(A_EOS, 32'h0);
      chk_rd("R10", "current cleared after pop", A_CUR, 32'h0);
      wr(A_MDIS, 32'hFFFF_FFFF);
   endtask

   task automatic t_arb_nest;
      wr(A_SPUR, 32'h5A5);
      wr(a_mode(2), 32'h03); wr(a_mode(9), 32'h03);
      wr(a_mode(12), 32'h05); wr(a_mode(20), 32'h01); wr(a_mode(30), 32'h06);
      wr(A_MEN, 32'h4010_1204);
      wr(A_PSET, 32'h0010_1204);
      chk_irq("R7", "empty stack lets source through", 1'b1);
      chk_rd("R6", "highest priority wins", A_ACK, 32'hA0C);
      chk_rd("R8", "current after first ack", A_CUR, 32'd12);
      chk_irq("R7", "lower priorities held back", 1'b0);
      chk_rd("R9", "blocked ack returns spurious", A_ACK, 32'h5A5);
      chk_rd("R9", "spurious ack keeps pending", A_PEND, 32'h0010_0204);
      chk_rd("R9", "spurious ack keeps current", A_CUR, 32'd12);
      wr(A_PSET, 32'h4000_0000);
      chk_irq("R7", "higher priority preempts", 1'b1);
      chk_rd("R8", "nested ack vector", A_ACK, 32'hA1E);
      chk_rd("R8", "current nested", A_CUR, 32'd30);
      wr(A_EOS, 32'h0);
      chk_rd("R10", "pop returns to 12", A_CUR, 32'd12);
      chk_irq("R7", "equal-or-lower still held", 1'b0);
      wr(A_EOS, 32'h0);
      chk_rd("R6", "tie goes to lowest number", A_ACK, 32'hA02);
      chk_irq("R7", "equal priority does not nest", 1'b0);
      wr(A_EOS, 32'h0);
      chk_rd("R6", "second of tie", A_ACK, 32'hA09);
      wr(A_EOS, 32'h0);
      chk_rd("R6", "lowest priority last", A_ACK, 32'hA14);
      wr(A_EOS, 32'h0);
      chk_rd("R9", "nothing left gives spurious", A_ACK, 32'h5A5);
      chk_rd("R9", "current 0 when idle", A_CUR, 32'h0);
      wr(A_MDIS, 32'hFFFF_FFFF);
   endtask

   task automatic t_deep;
      for (int i = 8; i < 16; i++) wr(a_mode(i), 32'(i - 8));
      wr(A_MEN, 32'h0000_FF00);
      for (int i = 8; i < 16; i++) begin
         logic [31:0] d;
         wr(A_PSET, 32'h1 << i);
         rd(A_ACK, d);
         check("R8", "deep nest ack vector", d, 32'hA00 + 32'(i));
      end
      chk_rd("R10", "eight levels, current 15", A_CUR, 32'd15);
      for (int i = 0; i < 7; i++) wr(A_EOS, 32'h0);
      chk_rd("R10", "seven pops leave 8", A_CUR, 32'd8);
      wr(A_EOS, 32'h0);
      chk_rd("R10", "eighth pop empties", A_CUR, 32'h0);
      wr(A_EOS, 32'h0);
      wr(A_PSET, 32'h0000_0100);
      chk_irq("R10", "extra pop harmless, priority 0 accepted", 1'b1);
      chk_rd("R10", "empty-stack ack vector", A_ACK, 32'hA08);
      wr(A_EOS, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      t_reset();
      t_mode_fields();
      t_mask();
      t_soft();
      t_level();
      t_edge();
      t_arb_nest();
      t_deep();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule